// File: doc/BRIEF.md
# Reloadable Interval Timer

This block is a 16-bit down-counter paired with a 16-bit reload latch. Software reaches it one byte at a time over an 8-bit register bus. The counter steps down by one in every cycle where the clock-enable input is high. When it runs out, the block raises a timer flag.

The latch and the counter are loaded through four byte-wide addresses. Two of them fill the low and high halves of the latch. A third also fills the high half and, in the same write, transfers the whole latch into the counter. The fourth returns the low half of the counter when read, and a write to it fills only the latch.

A mode bit in a small control register picks one of two behaviours. In free-running mode every expiry reloads the counter from the latch and sets the flag. In one-shot mode only the first expiry after a load sets the flag; after that the counter simply wraps and keeps counting. The flag is cleared by a dedicated pulse input or by a write to either latch-high address. A flag set that lands in the same cycle as a clear takes precedence.

Top module: `reload_timer`

## Requirements
- R1: After synchronous reset the counter, the latch, the mode bit, the flag and the one-shot arm all read as zero.
- R2: A write to offset 4 or offset 6 replaces the latch low byte and leaves the latch high byte and the counter unchanged.
- R3: A write to offset 7 replaces the latch high byte and clears the flag, and it leaves the counter unchanged.
- R4: A write to offset 5 replaces the latch high byte and, on the same edge, loads the counter with {written byte, latch low byte}. It also clears the flag and arms one-shot mode. This load takes precedence over any tick in that cycle.
- R5: Reads are combinational. Offset 4 returns counter bits 7:0, offset 5 returns counter bits 15:8, offset 6 returns latch bits 7:0 and offset 7 returns latch bits 15:8. Offset 11 returns the mode in bit 6 with all other bits zero. Every other offset returns zero.
- R6: In a cycle with tick_en high and no load, a counter value above 1 decrements by one. With tick_en low and no load, the counter holds its value.
- R7: In free-running mode (mode bit 1), a tick while the counter is 0 or 1 is an expiry. It loads the counter from the latch instead of decrementing.
- R8: In free-running mode, timer_flag goes high one edge after the edge on which the expiry updated the counter.
- R9: In one-shot mode (mode bit 0), an expiry decrements the counter normally, so 1 goes to 0 and 0 wraps to 0xFFFF. The flag is set, one edge later, only by the first expiry after a load. Later expiries leave the flag unchanged until the next offset-5 write.
- R10: A high flag_clr input, or a write to offset 5 or 7, clears timer_flag on the next edge. A pending flag set in the same cycle wins over the clear.
- R11: A write to offset 11 stores bit 6 of the written byte as the mode bit: 0 selects one-shot and 1 selects free-running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable: one decrement per high cycle |
| bus_wr | input | 1 | Register write strobe, one write per high cycle |
| bus_addr | input | 4 | Register offset for both read and write |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr |
| flag_clr | input | 1 | Flag clear pulse from the surrounding register logic |
| timer_flag | output | 1 | Timer interrupt flag |

## Verification
The assertions assume that every input holds a known 0 or 1 value from the first edge after reset. They also assume that a write asserted on bus_wr is taken in that single cycle with no hold-off. The counter assertions rely on the load strobe coming from the register decoder only in cycles where bus_wr is high at offset 5. The stimulus drives every input from defined values at the falling edge. It mixes mapped and unmapped offsets, ticks and clear pulses in arbitrary overlap, which includes clears that coincide with expiries and loads that coincide with ticks.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_LAT_LO = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_LAT_HI = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'd11;

    localparam int MODE_BIT = 6;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_FREERUN = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic lo_wr;
        logic hi_wr;
        logic load;
        logic ctrl_wr;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic wr, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d.lo_wr   = wr && ((a == OFS_CNT_LO) || (a == OFS_LAT_LO));
        d.hi_wr   = wr && ((a == OFS_CNT_HI) || (a == OFS_LAT_HI));
        d.load    = wr && (a == OFS_CNT_HI);
        d.ctrl_wr = wr && (a == OFS_CTRL);
        return d;
    endfunction

endpackage

// File: rtl/rtimer_regs.sv
module rtimer_regs
    import rtimer_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int CW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [CW-1:0]     latch,
    output run_mode_e         mode,
    output logic              load_en,
    output logic [CW-1:0]     load_val,
    output logic              wr_clr
);

    logic [DW-1:0] lat_lo_q;
    logic [DW-1:0] lat_hi_q;
    wr_dec_t       dec;

    assign dec      = decode_wr(wr, addr);
    assign latch    = {lat_hi_q, lat_lo_q};
    assign load_en  = dec.load;
    assign load_val = {wdata, lat_lo_q};
    assign wr_clr   = dec.hi_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo_q <= '0;
            lat_hi_q <= '0;
            mode     <= MODE_ONESHOT;
        end else begin
            if (dec.lo_wr)   lat_lo_q <= wdata;
            if (dec.hi_wr)   lat_hi_q <= wdata;
            if (dec.ctrl_wr) mode     <= run_mode_e'(wdata[MODE_BIT]);
        end
    end

    p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == OFS_LAT_LO || addr == OFS_CNT_LO))
        |=> (latch[CW-1:DW] == $past(latch[CW-1:DW])));

    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_LAT_HI) |=> (latch[DW-1:0] == $past(latch[DW-1:0])));

endmodule

// File: rtl/rtimer_count.sv
module rtimer_count
    import rtimer_pkg::*;
#(
    parameter int CW = 2 * DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] latch,
    input  run_mode_e     mode,
    output logic [CW-1:0] count,
    output logic          pend_set
);

    logic armed_q;
    logic expire;

    assign expire = tick && !load_en && (count <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            armed_q  <= 1'b0;
            pend_set <= 1'b0;
        end else begin
            pend_set <= 1'b0;
            if (load_en) begin
                count   <= load_val;
                armed_q <= 1'b1;
            end else if (expire) begin
                if (mode == MODE_FREERUN) begin
                    count    <= latch;
                    pend_set <= 1'b1;
                end else begin
                    count    <= count - CW'(1);
                    pend_set <= armed_q;
                    armed_q  <= 1'b0;
                end
            end else if (tick) begin
                count <= count - CW'(1);
            end
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_en) |=> (count == $past(count)));

    p_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && count > CW'(1)) |=> (count == $past(count) - CW'(1)));

    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (expire && mode == MODE_FREERUN) |=> (count == $past(latch)));

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count == $past(load_val)));

    p_oneshot_once_r9: assert property (@(posedge clk) disable iff (rst)
        (expire && mode == MODE_ONESHOT) |=> ##1 !(expire && mode == MODE_ONESHOT && pend_set && $past(pend_set, 1)));

endmodule

// File: rtl/rtimer_flag.sv
module rtimer_flag (
    input  logic clk,
    input  logic rst,
    input  logic pend_set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (pend_set) flag <= 1'b1;
        else if (clr)      flag <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        pend_set |=> flag);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !pend_set) |=> !flag);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rtimer_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int CW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              flag_clr,
    output logic              timer_flag
);

    logic [CW-1:0] latch;
    logic [CW-1:0] count;
    logic [CW-1:0] load_val;
    run_mode_e     mode;
    logic          load_en;
    logic          wr_clr;
    logic          pend_set;

    rtimer_regs #(.DW(DW)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .latch    (latch),
        .mode     (mode),
        .load_en  (load_en),
        .load_val (load_val),
        .wr_clr   (wr_clr)
    );

    rtimer_count #(.CW(CW)) count_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .load_en  (load_en),
        .load_val (load_val),
        .latch    (latch),
        .mode     (mode),
        .count    (count),
        .pend_set (pend_set)
    );

    rtimer_flag flag_i (
        .clk      (clk),
        .rst      (rst),
        .pend_set (pend_set),
        .clr      (wr_clr | flag_clr),
        .flag     (timer_flag)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT_LO: bus_rdata = count[DW-1:0];
            OFS_CNT_HI: bus_rdata = count[CW-1:DW];
            OFS_LAT_LO: bus_rdata = latch[DW-1:0];
            OFS_LAT_HI: bus_rdata = latch[CW-1:DW];
            OFS_CTRL:   bus_rdata[MODE_BIT] = mode;
            default:    bus_rdata = '0;
        endcase
    end

    p_offset7_no_load_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LAT_HI && !tick_en) |=> (count == $past(count)));

    p_wrclr_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LAT_HI && !pend_set) |=> !timer_flag);

endmodule

// File: tb/reload_timer_tb_top.sv
`timescale 1ns/1ps
module reload_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       flag_clr = 1'b0;
    logic       timer_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reload_timer dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .flag_clr   (flag_clr),
        .timer_flag (timer_flag)
    );

    // behavioural reference state
    int m_cnt = 0, m_lat = 0, m_mode = 0, m_arm = 0, m_pend = 0, m_flag = 0;

    always @(posedge clk) begin
        int n_cnt, n_lat, n_mode, n_arm, n_pend, n_flag, a;
        if (rst) begin
            m_cnt = 0; m_lat = 0; m_mode = 0; m_arm = 0; m_pend = 0; m_flag = 0;
        end else begin
            a = bus_addr;
            n_cnt = m_cnt; n_lat = m_lat; n_mode = m_mode; n_arm = m_arm; n_pend = 0;
            if (m_pend != 0) n_flag = 1;
            else if (flag_clr || (bus_wr && (a == 5 || a == 7))) n_flag = 0;
            else n_flag = m_flag;
            if (bus_wr && (a == 4 || a == 6)) n_lat = (m_lat & 'hFF00) | bus_wdata;
            if (bus_wr && (a == 5 || a == 7)) n_lat = (m_lat & 'h00FF) | (bus_wdata << 8);
            if (bus_wr && a == 11) n_mode = bus_wdata[6];
            if (bus_wr && a == 5) begin
                n_cnt = (bus_wdata << 8) | (m_lat & 'hFF);
                n_arm = 1;
            end else if (tick_en) begin
                if (m_cnt <= 1 && m_mode == 1) begin
                    n_cnt = m_lat;
                    n_pend = 1;
                end else begin
                    n_cnt = (m_cnt + 65535) % 65536;
                    if (m_cnt <= 1) begin
                        n_pend = m_arm;
                        n_arm = 0;
                    end
                end
            end
            m_cnt = n_cnt; m_lat = n_lat; m_mode = n_mode;
            m_arm = n_arm; m_pend = n_pend; m_flag = n_flag;
        end
    end

    function automatic int model_rd(input int a);
        case (a)
            4: return m_cnt & 'hFF;
            5: return (m_cnt >> 8) & 'hFF;
            6: return m_lat & 'hFF;
            7: return (m_lat >> 8) & 'hFF;
            11: return m_mode << 6;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: compare against the model, then drive the next inputs
    task automatic cyc(input bit wr, input int a, input int d, input bit tk, input bit fc);
        @(negedge clk);
        if (!rst) begin
            check("R5/R6 cycle rdata vs model", bus_rdata, model_rd(bus_addr));
            check("R8/R10 cycle flag vs model", timer_flag, m_flag);
        end
        bus_wr = wr; bus_addr = a[3:0]; bus_wdata = d[7:0];
        tick_en = tk; flag_clr = fc;
    endtask

    task automatic expect_rd(input int a, input int exp, input string tag);
        cyc(0, a, 0, 0, 0);
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic expect_flag(input int exp, input string tag);
        cyc(0, 4, 0, 0, 0);
        #1;
        check(tag, timer_flag, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_rd(4, 0, "R1 counter lo");
        expect_rd(5, 0, "R1 counter hi");
        expect_rd(6, 0, "R1 latch lo");
        expect_rd(7, 0, "R1 latch hi");
        expect_rd(11, 0, "R1 mode");
        expect_flag(0, "R1 flag");
        expect_rd(0, 0, "R5 unmapped offset");
        // R2 low byte writes
        cyc(1, 6, 'h05, 0, 0);
        expect_rd(6, 'h05, "R2 latch lo via 6");
        expect_rd(4, 0, "R2 counter untouched");
        cyc(1, 4, 'h03, 0, 0);
        expect_rd(6, 'h03, "R2 latch lo via 4");
        // R3 latch-high-only write
        cyc(1, 7, 'h12, 0, 0);
        expect_rd(7, 'h12, "R3 latch hi");
        expect_rd(5, 0, "R3 counter hi untouched");
        // R4 load
        cyc(1, 5, 'h00, 0, 0);
        expect_rd(4, 'h03, "R4 counter lo loaded");
        expect_rd(5, 'h00, "R4 counter hi loaded");
        expect_rd(7, 'h00, "R4 latch hi");
        // R11 free-running mode
        cyc(1, 11, 'h40, 0, 0);
        expect_rd(11, 'h40, "R11 mode readback");
        // R6 decrement and hold
        cyc(0, 4, 0, 1, 0);
        expect_rd(4, 'h02, "R6 decrement");
        expect_rd(4, 'h02, "R6 hold without tick");
        cyc(0, 4, 0, 1, 0);
        cyc(0, 4, 0, 1, 0);
        // R7 reload, R8 flag one edge later
        cyc(0, 4, 0, 0, 0);
        #1;
        check("R7 reload from latch", bus_rdata, 'h03);
        check("R8 flag not yet", timer_flag, 0);
        expect_flag(1, "R8 flag set");
        // R10 clear by pulse
        cyc(0, 4, 0, 0, 1);
        expect_flag(0, "R10 pulse clears flag");
        // R10 clear vs set collision: count is 3
        cyc(0, 4, 0, 1, 0);
        cyc(0, 4, 0, 1, 0);
        cyc(0, 4, 0, 1, 1);
        cyc(0, 4, 0, 0, 1);
        expect_flag(1, "R10 set wins over clear");
        // R3 write to offset 7 clears flag
        cyc(1, 7, 'h00, 0, 0);
        expect_flag(0, "R3 offset 7 clears flag");
        // R9 one-shot
        cyc(1, 11, 'h00, 0, 0);
        cyc(1, 6, 'h02, 0, 0);
        cyc(1, 5, 'h00, 0, 0);
        cyc(0, 4, 0, 1, 0);
        cyc(0, 4, 0, 1, 0);
        expect_rd(4, 'h00, "R9 reaches zero");
        expect_flag(1, "R9 first expiry flags");
        cyc(0, 4, 0, 0, 1);
        cyc(0, 4, 0, 1, 0);
        expect_rd(4, 'hFF, "R9 wrap lo");
        expect_rd(5, 'hFF, "R9 wrap hi");
        expect_flag(0, "R9 no second flag");
        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r, a;
            r = $urandom_range(0, 99);
            case ($urandom_range(0, 6))
                0: a = 4;
                1: a = 5;
                2: a = 6;
                3: a = 7;
                4: a = 11;
                5: a = $urandom_range(0, 15);
                default: a = 4;
            endcase
            cyc(r < 8, a, (a == 5 || a == 7) ? $urandom_range(0, 1) : $urandom_range(0, 255),
                $urandom_range(0, 9) < 7, $urandom_range(0, 19) == 0);
        end
        cyc(0, 4, 0, 0, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule